// File: doc/BRIEF.md
# LCD Video Timing Generator

This block produces the raster timing for a parallel RGB LCD panel: horizontal sync, vertical sync, a data-enable strobe and the column and row coordinates of the current active pixel. It counts on a pixel tick that is either every clock or every (divider + 1) clocks, and all geometry comes from a small register write port. Each line runs sync pulse, back porch, active pixels, front porch; each frame runs the same four regions counted in lines.

Timing, divider, clock-select and the second display enable sit in a staged bank. Software may rewrite them at any time. The running frame keeps its geometry, and the staged values move to the working set only at the tick that closes a frame and opens the next vertical sync. While the raster is stopped the working set follows the staged bank on every clock. A frame event, taken from entry into a selectable vertical region, sets a sticky pending flag, and an interrupt line reports that flag through two enable bits.

Top module: `lcd_tgen_top`

## Requirements
- R1: After reset, hsync_o and vsync_o are high (inactive, active-low default), de_o, pix_x_o, pix_y_o and irq_o are 0, and every register field is 0.
- R2: While running, each line is hsync pulse for (HTIM[7:0]+1) ticks, back porch (HTIM[15:8]+1), active (SIZE[11:0]+1), front porch (HTIM[23:16]+1), with register HTIM at address 1 and SIZE at address 3.
- R3: While running, each frame is vsync for (VTIM[7:0]+1) lines, back porch (VTIM[15:8]+1), active (SIZE[27:16]+1), front porch (VTIM[23:16]+1); VTIM is at address 2 and the vertical region advances only at the last tick of a line.
- R4: de_o is high only when both the horizontal and vertical positions are in their active regions; pix_x_o and pix_y_o count from 0 there and read 0 elsewhere.
- R5: With CTRL (address 0) bit 2 clear a pixel tick occurs every clock; with it set a tick occurs every (CTRL[15:8]+1) clocks.
- R6: CTRL bits 1, 2, 15:8 and all of HTIM, VTIM and SIZE are staged: a write while running changes nothing until the tick that ends the current frame; while stopped they reach the working set one clock after the write.
- R7: The raster runs only while CTRL bit 0 (direct enable) and the working copy of CTRL bit 1 are both set; clearing bit 0 stops it at once and returns it to the frame start, clearing bit 1 stops it at the end of the frame.
- R8: CTRL bit 4 sets hsync polarity and bit 5 vsync polarity (0 active-low, 1 active-high), effective one clock after the write.
- R9: A frame event occurs when the vertical position enters the region chosen by ICTL (address 4) bits 3:2 (0 sync, 1 back porch, 2 active, 3 front porch); the start of running counts as entering sync. The event sets the pending flag one clock later.
- R10: Writing 1 to bit 0 of address 5 clears the pending flag; writing 0 leaves it; an event in the same clock wins.
- R11: irq_o equals the pending flag AND ICTL bit 0 (master) AND ICTL bit 1 (frame enable); the pending flag keeps its value while either enable is off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register address |
| wr_data | input | DATA_W | Register write data |
| hsync_o | output | 1 | Horizontal sync, polarity per CTRL bit 4 |
| vsync_o | output | 1 | Vertical sync, polarity per CTRL bit 5 |
| de_o | output | 1 | Data enable |
| pix_x_o | output | SIZE_W | Column within the active area |
| pix_y_o | output | SIZE_W | Row within the active area |
| irq_o | output | 1 | Frame interrupt |

## Verification
The bench rewrites geometry and the divider in the middle of a frame; a design that reloaded at once would shorten or stretch the current line and break the line and frame counts the model expects. It drops the second enable mid-frame and the direct enable mid-line, catching a raster that stops at the wrong point or fails to return to the frame start. It moves the event source across all four vertical regions and clears the pending flag while the interrupt is masked, so an off-by-one region entry, a missed start-of-run event or a clear that also erases the flag behind the masks shows up on irq_o. Polarity flips while running expose a sync output that ignores the invert bits or inverts the data-enable.

// File: rtl/lcd_tgen_pkg.sv
`timescale 1ns/1ps
package lcd_tgen_pkg;

   // Raster regions in the order they are visited on both axes.
   typedef enum logic [1:0] {
      PH_SYNC  = 2'd0,
      PH_BACK  = 2'd1,
      PH_ACT   = 2'd2,
      PH_FRONT = 2'd3
   } tg_phase_e;

   // Register addresses.
   localparam int unsigned REG_CTRL  = 0;
   localparam int unsigned REG_HTIM  = 1;
   localparam int unsigned REG_VTIM  = 2;
   localparam int unsigned REG_SIZE  = 3;
   localparam int unsigned REG_ICTL  = 4;
   localparam int unsigned REG_ISTAT = 5;

   // Control word bit positions.
   localparam int unsigned CB_EN      = 0;
   localparam int unsigned CB_SEN     = 1;
   localparam int unsigned CB_CLKSEL  = 2;
   localparam int unsigned CB_HPOL    = 4;
   localparam int unsigned CB_VPOL    = 5;
   localparam int unsigned CB_DIV_LSB = 8;

   // Size word: vertical field lsb.
   localparam int unsigned SZ_V_LSB = 16;

   // Interrupt control bit positions.
   localparam int unsigned IB_MASTER  = 0;
   localparam int unsigned IB_FRAME   = 1;
   localparam int unsigned IB_SRC_LSB = 2;

endpackage

// File: rtl/lcd_tgen_regs.sv
`timescale 1ns/1ps
module lcd_tgen_regs
   import lcd_tgen_pkg::*;
#(
   parameter int PORCH_W = 8,
   parameter int SIZE_W  = 12,
   parameter int DIV_W   = 8,
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              commit_i,
   output logic              run_o,
   output logic              clksel_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [PORCH_W-1:0] hspw_o,
   output logic [PORCH_W-1:0] hbp_o,
   output logic [PORCH_W-1:0] hfp_o,
   output logic [PORCH_W-1:0] vspw_o,
   output logic [PORCH_W-1:0] vbp_o,
   output logic [PORCH_W-1:0] vfp_o,
   output logic [SIZE_W-1:0]  hact_o,
   output logic [SIZE_W-1:0]  vact_o,
   output logic              hpol_o,
   output logic              vpol_o,
   output logic              imaster_o,
   output logic              iframe_o,
   output logic [1:0]        isrc_o,
   output logic              clr_pend_o
);

   localparam int P0 = 0;
   localparam int P1 = PORCH_W;
   localparam int P2 = 2 * PORCH_W;

   logic sel_ctrl, sel_htim, sel_vtim, sel_size, sel_ictl, sel_istat;

   always_comb begin
      sel_ctrl  = wr_en && (wr_addr == ADDR_W'(REG_CTRL));
      sel_htim  = wr_en && (wr_addr == ADDR_W'(REG_HTIM));
      sel_vtim  = wr_en && (wr_addr == ADDR_W'(REG_VTIM));
      sel_size  = wr_en && (wr_addr == ADDR_W'(REG_SIZE));
      sel_ictl  = wr_en && (wr_addr == ADDR_W'(REG_ICTL));
      sel_istat = wr_en && (wr_addr == ADDR_W'(REG_ISTAT));
   end

   // Direct (unstaged) fields.
   logic en_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         hpol_o    <= 1'b0;
         vpol_o    <= 1'b0;
         imaster_o <= 1'b0;
         iframe_o  <= 1'b0;
         isrc_o    <= 2'd0;
      end else begin
         if (sel_ctrl) begin
            en_q   <= wr_data[CB_EN];
            hpol_o <= wr_data[CB_HPOL];
            vpol_o <= wr_data[CB_VPOL];
         end
         if (sel_ictl) begin
            imaster_o <= wr_data[IB_MASTER];
            iframe_o  <= wr_data[IB_FRAME];
            isrc_o    <= wr_data[IB_SRC_LSB +: 2];
         end
      end
   end

   assign clr_pend_o = sel_istat && wr_data[0];

   // Staged bank written by software.
   logic               st_sen, st_sel;
   logic [DIV_W-1:0]   st_div;
   logic [PORCH_W-1:0] st_hspw, st_hbp, st_hfp, st_vspw, st_vbp, st_vfp;
   logic [SIZE_W-1:0]  st_hact, st_vact;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_sen  <= 1'b0;
         st_sel  <= 1'b0;
         st_div  <= '0;
         st_hspw <= '0;
         st_hbp  <= '0;
         st_hfp  <= '0;
         st_vspw <= '0;
         st_vbp  <= '0;
         st_vfp  <= '0;
         st_hact <= '0;
         st_vact <= '0;
      end else begin
         if (sel_ctrl) begin
            st_sen <= wr_data[CB_SEN];
            st_sel <= wr_data[CB_CLKSEL];
            st_div <= wr_data[CB_DIV_LSB +: DIV_W];
         end
         if (sel_htim) begin
            st_hspw <= wr_data[P0 +: PORCH_W];
            st_hbp  <= wr_data[P1 +: PORCH_W];
            st_hfp  <= wr_data[P2 +: PORCH_W];
         end
         if (sel_vtim) begin
            st_vspw <= wr_data[P0 +: PORCH_W];
            st_vbp  <= wr_data[P1 +: PORCH_W];
            st_vfp  <= wr_data[P2 +: PORCH_W];
         end
         if (sel_size) begin
            st_hact <= wr_data[0 +: SIZE_W];
            st_vact <= wr_data[SZ_V_LSB +: SIZE_W];
         end
      end
   end

   // Working bank: follows the staged bank while stopped, else at frame wrap.
   logic act_sen, load;
   assign run_o = en_q && act_sen;
   assign load  = !run_o || commit_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_sen  <= 1'b0;
         clksel_o <= 1'b0;
         div_o    <= '0;
         hspw_o   <= '0;
         hbp_o    <= '0;
         hfp_o    <= '0;
         vspw_o   <= '0;
         vbp_o    <= '0;
         vfp_o    <= '0;
         hact_o   <= '0;
         vact_o   <= '0;
      end else if (load) begin
         act_sen  <= st_sen;
         clksel_o <= st_sel;
         div_o    <= st_div;
         hspw_o   <= st_hspw;
         hbp_o    <= st_hbp;
         hfp_o    <= st_hfp;
         vspw_o   <= st_vspw;
         vbp_o    <= st_vbp;
         vfp_o    <= st_vfp;
         hact_o   <= st_hact;
         vact_o   <= st_vact;
      end
   end

   logic unused_wdata;
   assign unused_wdata = ^wr_data;

endmodule

// File: rtl/lcd_tgen_pixdiv.sv
`timescale 1ns/1ps
module lcd_tgen_pixdiv #(
   parameter int DIV_W       = 8,
   parameter bit HAS_DIVIDER = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             clksel_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   generate
      if (HAS_DIVIDER) begin : g_div
         logic [DIV_W-1:0] dcnt_q;
         logic             at_limit;

         assign at_limit = (dcnt_q == div_i);
         assign tick_o   = run_i && (!clksel_i || at_limit);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dcnt_q <= '0;
            end else if (!run_i || tick_o) begin
               dcnt_q <= '0;
            end else begin
               dcnt_q <= dcnt_q + 1'b1;
            end
         end
      end else begin : g_direct
         logic unused_div;
         assign unused_div = clksel_i ^ (^div_i) ^ clk ^ rst_n;
         assign tick_o     = run_i;
      end
   endgenerate

endmodule

// File: rtl/lcd_tgen_axis.sv
`timescale 1ns/1ps
module lcd_tgen_axis
   import lcd_tgen_pkg::*;
#(
   parameter int PORCH_W = 8,
   parameter int SIZE_W  = 12,
   parameter int CNT_W   = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr_i,
   input  logic               step_i,
   input  logic [PORCH_W-1:0] spw_i,
   input  logic [PORCH_W-1:0] bp_i,
   input  logic [PORCH_W-1:0] fp_i,
   input  logic [SIZE_W-1:0]  act_i,
   output logic [1:0]         ph_o,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               last_o
);

   if (CNT_W < PORCH_W || CNT_W < SIZE_W) begin : g_bad_cnt
      $error("lcd_tgen_axis: CNT_W narrower than a field");
   end

   logic [CNT_W-1:0] limit;
   logic             at_limit;

   always_comb begin
      case (ph_o)
         PH_SYNC:  limit = CNT_W'(spw_i);
         PH_BACK:  limit = CNT_W'(bp_i);
         PH_ACT:   limit = CNT_W'(act_i);
         default:  limit = CNT_W'(fp_i);
      endcase
   end

   assign at_limit = (cnt_o == limit);
   assign last_o   = (ph_o == PH_FRONT) && at_limit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_o  <= PH_SYNC;
         cnt_o <= '0;
      end else if (clr_i) begin
         ph_o  <= PH_SYNC;
         cnt_o <= '0;
      end else if (step_i) begin
         if (at_limit) begin
            ph_o  <= ph_o + 2'd1;
            cnt_o <= '0;
         end else begin
            cnt_o <= cnt_o + 1'b1;
         end
      end
   end

endmodule

// File: rtl/lcd_tgen_irq.sv
`timescale 1ns/1ps
module lcd_tgen_irq
   import lcd_tgen_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run_i,
   input  logic [1:0] v_ph_i,
   input  logic [1:0] src_i,
   input  logic       master_i,
   input  logic       frame_en_i,
   input  logic       clr_i,
   output logic       event_o,
   output logic       pend_o,
   output logic       irq_o
);

   localparam int NSRC = 4;

   logic [1:0]      prev_q;
   logic [NSRC-1:0] enter;

   // One entry detector per vertical region.
   for (genvar i = 0; i < NSRC; i++) begin : g_src
      assign enter[i] = run_i && (v_ph_i == 2'(i)) && (prev_q != 2'(i));
   end

   assign event_o = enter[src_i];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= PH_FRONT;
         pend_o <= 1'b0;
      end else begin
         prev_q <= run_i ? v_ph_i : PH_FRONT;
         pend_o <= (pend_o && !clr_i) || event_o;
      end
   end

   assign irq_o = pend_o && master_i && frame_en_i;

endmodule

// File: rtl/lcd_tgen_top.sv
`timescale 1ns/1ps
module lcd_tgen_top
   import lcd_tgen_pkg::*;
#(
   parameter int PORCH_W     = 8,
   parameter int SIZE_W      = 12,
   parameter int DIV_W       = 8,
   parameter int ADDR_W      = 3,
   parameter int DATA_W      = 32,
   parameter bit HAS_DIVIDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              de_o,
   output logic [SIZE_W-1:0] pix_x_o,
   output logic [SIZE_W-1:0] pix_y_o,
   output logic              irq_o
);

   localparam int CNT_W    = (SIZE_W > PORCH_W) ? SIZE_W : PORCH_W;
   localparam int ACT_BITS = 2 + DIV_W + 6 * PORCH_W + 2 * SIZE_W;

   if (3 * PORCH_W > DATA_W) begin : g_bad_porch
      $error("lcd_tgen_top: porch fields do not fit the data word");
   end
   if (SIZE_W > 16 || SZ_V_LSB + SIZE_W > DATA_W) begin : g_bad_size
      $error("lcd_tgen_top: size fields do not fit the data word");
   end
   if (DIV_W < 1 || CB_DIV_LSB + DIV_W > DATA_W) begin : g_bad_div
      $error("lcd_tgen_top: divider field does not fit the data word");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("lcd_tgen_top: address too narrow for the register map");
   end

   logic               run, clksel, hpol, vpol, imaster, iframe, clr_pend;
   logic [1:0]         isrc;
   logic [DIV_W-1:0]   div;
   logic [PORCH_W-1:0] hspw, hbp, hfp, vspw, vbp, vfp;
   logic [SIZE_W-1:0]  hact, vact;
   logic               tick, commit, h_last, v_last, ev, pend;
   logic [1:0]         h_ph, v_ph;
   logic [CNT_W-1:0]   h_cnt, v_cnt;
   logic [ACT_BITS-1:0] act_bundle;

   lcd_tgen_regs #(
      .PORCH_W(PORCH_W), .SIZE_W(SIZE_W), .DIV_W(DIV_W),
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .commit_i(commit),
      .run_o(run), .clksel_o(clksel), .div_o(div),
      .hspw_o(hspw), .hbp_o(hbp), .hfp_o(hfp),
      .vspw_o(vspw), .vbp_o(vbp), .vfp_o(vfp),
      .hact_o(hact), .vact_o(vact),
      .hpol_o(hpol), .vpol_o(vpol),
      .imaster_o(imaster), .iframe_o(iframe), .isrc_o(isrc),
      .clr_pend_o(clr_pend)
   );

   lcd_tgen_pixdiv #(.DIV_W(DIV_W), .HAS_DIVIDER(HAS_DIVIDER)) u_div (
      .clk(clk), .rst_n(rst_n), .run_i(run),
      .clksel_i(clksel), .div_i(div), .tick_o(tick)
   );

   lcd_tgen_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_h (
      .clk(clk), .rst_n(rst_n), .clr_i(!run), .step_i(tick),
      .spw_i(hspw), .bp_i(hbp), .fp_i(hfp), .act_i(hact),
      .ph_o(h_ph), .cnt_o(h_cnt), .last_o(h_last)
   );

   lcd_tgen_axis #(.PORCH_W(PORCH_W), .SIZE_W(SIZE_W), .CNT_W(CNT_W)) u_v (
      .clk(clk), .rst_n(rst_n), .clr_i(!run), .step_i(tick && h_last),
      .spw_i(vspw), .bp_i(vbp), .fp_i(vfp), .act_i(vact),
      .ph_o(v_ph), .cnt_o(v_cnt), .last_o(v_last)
   );

   assign commit = tick && h_last && v_last;

   lcd_tgen_irq u_irq (
      .clk(clk), .rst_n(rst_n), .run_i(run), .v_ph_i(v_ph),
      .src_i(isrc), .master_i(imaster), .frame_en_i(iframe),
      .clr_i(clr_pend), .event_o(ev), .pend_o(pend), .irq_o(irq_o)
   );

   logic hs_on, vs_on;
   assign hs_on   = run && (h_ph == PH_SYNC);
   assign vs_on   = run && (v_ph == PH_SYNC);
   assign hsync_o = hpol ? hs_on : !hs_on;
   assign vsync_o = vpol ? vs_on : !vs_on;

   assign de_o    = run && (h_ph == PH_ACT) && (v_ph == PH_ACT);
   assign pix_x_o = de_o ? h_cnt[SIZE_W-1:0] : '0;
   assign pix_y_o = de_o ? v_cnt[SIZE_W-1:0] : '0;

   assign act_bundle = {clksel, div, hspw, hbp, hfp, vspw, vbp, vfp, hact, vact};

   logic unused_cnt;
   assign unused_cnt = ^{h_cnt, v_cnt};

endmodule

// File: rtl/lcd_tgen_chk.sv
`timescale 1ns/1ps
module lcd_tgen_chk #(
   parameter int ACT_BITS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                run,
   input logic                tick,
   input logic                commit,
   input logic [1:0]          h_ph,
   input logic [1:0]          v_ph,
   input logic                h_last,
   input logic                pend,
   input logic                clr_pend,
   input logic                ev,
   input logic [ACT_BITS-1:0] act_bundle
);

   // R2: horizontal regions are visited in order
   a_r2_h_order: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (h_ph != $past(h_ph))) |-> (h_ph == $past(h_ph) + 2'd1));

   // R3: vertical region moves only on the last tick of a line
   a_r3_v_on_line_end: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && (v_ph != $past(v_ph))) |-> $past(h_last && tick));

   // R6: working geometry holds during a running frame
   a_r6_hold_midframe: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !commit) |=> $stable(act_bundle));

   // R10: pending stays set until cleared
   a_r10_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !clr_pend) |=> pend);

   // R10: clear without an event empties the flag
   a_r10_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_pend && !ev) |=> !pend);

   // R9: an event always leaves the flag set
   a_r9_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
      ev |=> pend);

endmodule

bind lcd_tgen_top lcd_tgen_chk #(.ACT_BITS(ACT_BITS)) u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .commit(commit),
   .h_ph(h_ph), .v_ph(v_ph), .h_last(h_last), .pend(pend),
   .clr_pend(clr_pend), .ev(ev), .act_bundle(act_bundle)
);

// File: tb/lcd_tgen_top_test.sv
`timescale 1ns/1ps
module lcd_tgen_top_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        hsync_o, vsync_o, de_o, irq_o;
   logic [11:0] pix_x_o, pix_y_o;

   always #10 clk = ~clk;

   lcd_tgen_top uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .hsync_o(hsync_o), .vsync_o(vsync_o),
      .de_o(de_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o), .irq_o(irq_o)
   );

   int    n_checks = 0;
   int    n_fail   = 0;
   int    cycles   = 0;
   bit    checking = 0;
   bit    done     = 0;
   string ctx      = "R1 reset";

   // Reference model state (register words and raster positions).
   int unsigned m_ctrl = 0, m_ictl = 0;
   int unsigned s_htim = 0, s_vtim = 0, s_size = 0;
   int unsigned a_sen = 0, a_sel = 0, a_div = 0;
   int unsigned a_htim = 0, a_vtim = 0, a_size = 0;
   int hpos = 0, vpos = 0, dcnt = 0, prevv = 3;
   bit pend = 0;

   function automatic int region(int pos, int s, int b, int a);
      if (pos < s) return 0;
      if (pos < s + b) return 1;
      if (pos < s + b + a) return 2;
      return 3;
   endfunction

   function automatic int fld(int unsigned w, int lsb, int width);
      return int'((w >> lsb) & ((1 << width) - 1)) + 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = 0; m_ictl = 0; s_htim = 0; s_vtim = 0; s_size = 0;
         a_sen = 0; a_sel = 0; a_div = 0; a_htim = 0; a_vtim = 0; a_size = 0;
         hpos = 0; vpos = 0; dcnt = 0; prevv = 3; pend = 0;
      end else begin
         bit run, tick, hl, vl, ev, clr;
         int hs, hb, ha, hf, vs, vb, va, vf, vph;
         hs = fld(a_htim, 0, 8); hb = fld(a_htim, 8, 8); hf = fld(a_htim, 16, 8);
         vs = fld(a_vtim, 0, 8); vb = fld(a_vtim, 8, 8); vf = fld(a_vtim, 16, 8);
         ha = fld(a_size, 0, 12); va = fld(a_size, 16, 12);
         run  = m_ctrl[0] && (a_sen != 0);
         tick = run && (a_sel == 0 || dcnt == int'(a_div));
         hl   = (hpos == hs + hb + ha + hf - 1);
         vl   = (vpos == vs + vb + va + vf - 1);
         vph  = region(vpos, vs, vb, va);
         ev   = run && vph != prevv && vph == int'((m_ictl >> 2) & 3);
         clr  = wr_en && wr_addr == 3'd5 && wr_data[0];
         if (!run) begin
            hpos = 0; vpos = 0; dcnt = 0; prevv = 3;
            a_sen = (m_ctrl >> 1) & 1; a_sel = (m_ctrl >> 2) & 1; a_div = (m_ctrl >> 8) & 8'hff;
            a_htim = s_htim; a_vtim = s_vtim; a_size = s_size;
         end else begin
            prevv = vph;
            if (tick) begin
               dcnt = 0;
               if (hl) begin
                  hpos = 0;
                  vpos = vl ? 0 : vpos + 1;
                  if (vl) begin
                     a_sen = (m_ctrl >> 1) & 1; a_sel = (m_ctrl >> 2) & 1; a_div = (m_ctrl >> 8) & 8'hff;
                     a_htim = s_htim; a_vtim = s_vtim; a_size = s_size;
                  end
               end else hpos = hpos + 1;
            end else dcnt = dcnt + 1;
         end
         pend = (pend && !clr) || ev;
         if (wr_en) begin
            case (wr_addr)
               3'd0: m_ctrl = wr_data;
               3'd1: s_htim = wr_data;
               3'd2: s_vtim = wr_data;
               3'd3: s_size = wr_data;
               3'd4: m_ictl = wr_data;
               default: ;
            endcase
         end
      end
   end

   task automatic chk(string req, string name, int act, int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s [%s] %s actual=%0d expected=%0d at cycle %0d", req, ctx, name, act, exp, cycles);
      end
   endtask

   // Compare every output on every clock, away from the active edge.
   always @(negedge clk) begin
      cycles++;
      if (checking) begin
         int hs, hb, ha, hf, vs, vb, va, vf, hph, vph;
         bit run, de, e_hs, e_vs;
         hs = fld(a_htim, 0, 8); hb = fld(a_htim, 8, 8); hf = fld(a_htim, 16, 8);
         vs = fld(a_vtim, 0, 8); vb = fld(a_vtim, 8, 8); vf = fld(a_vtim, 16, 8);
         ha = fld(a_size, 0, 12); va = fld(a_size, 16, 12);
         run  = m_ctrl[0] && (a_sen != 0);
         hph  = region(hpos, hs, hb, ha);
         vph  = region(vpos, vs, vb, va);
         de   = run && hph == 2 && vph == 2;
         e_hs = run && hph == 0;
         e_vs = run && vph == 0;
         chk("R2 R8", "hsync_o", int'(hsync_o), int'(m_ctrl[4] ? e_hs : !e_hs));
         chk("R3 R8", "vsync_o", int'(vsync_o), int'(m_ctrl[5] ? e_vs : !e_vs));
         chk("R4", "de_o", int'(de_o), int'(de));
         chk("R4", "pix_x_o", int'(pix_x_o), de ? hpos - hs - hb : 0);
         chk("R4", "pix_y_o", int'(pix_y_o), de ? vpos - vs - vb : 0);
         chk("R9 R11", "irq_o", int'(irq_o), int'(pend && m_ictl[0] && m_ictl[1]));
      end
      if (cycles > 100000 && !done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<=100000", cycles);
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   task automatic wr(int unsigned a, int unsigned d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   localparam int unsigned HT0 = (32'd1 << 16) | (32'd2 << 8) | 32'd1;
   localparam int unsigned VT0 = (32'd0 << 16) | (32'd1 << 8) | 32'd0;
   localparam int unsigned SZ0 = (32'd3 << 16) | 32'd7;
   localparam int unsigned HT1 = (32'd2 << 16) | (32'd1 << 8) | 32'd0;
   localparam int unsigned SZ1 = (32'd2 << 16) | 32'd5;

   initial begin
      checking = 1;
      idle(4);
      // R1: outputs idle during and right after reset
      rst_n = 1'b1;
      idle(3);

      ctx = "R2 R3 R4 R9 R11 run 1:1 vsync source";
      wr(1, HT0); wr(2, VT0); wr(3, SZ0);
      wr(4, 32'h3);
      wr(0, 32'h3);
      idle(300);

      ctx = "R10 clear pending, write 0 ignored";
      wr(5, 32'h0); idle(3);
      wr(5, 32'h1); idle(100);

      ctx = "R6 R5 staged geometry and divider mid-frame";
      idle(37);
      wr(1, HT1); wr(3, SZ1);
      wr(0, 32'h3 | 32'h4 | (32'd2 << 8));
      idle(1500);

      ctx = "R8 polarity invert";
      wr(0, 32'h3 | 32'h4 | (32'd2 << 8) | 32'h30);
      idle(400);

      ctx = "R9 source active region";
      wr(5, 32'h1); wr(4, 32'h3 | (32'd2 << 2)); idle(700);
      ctx = "R9 source front porch";
      wr(5, 32'h1); wr(4, 32'h3 | (32'd3 << 2)); idle(700);
      ctx = "R9 source back porch";
      wr(5, 32'h1); wr(4, 32'h3 | (32'd1 << 2)); idle(700);

      ctx = "R11 masked pending held";
      wr(4, 32'd1 << 2); idle(500);
      wr(4, 32'h1 | (32'd1 << 2)); idle(20);
      wr(4, 32'h3 | (32'd1 << 2)); idle(20);

      ctx = "R7 second enable cleared mid-frame";
      wr(0, 32'h1 | 32'h4 | (32'd2 << 8));
      idle(1200);

      ctx = "R7 restart 1:1";
      wr(0, 32'h3); idle(263);
      ctx = "R7 direct enable cleared mid-line";
      wr(0, 32'h2); idle(50);
      ctx = "R7 R6 restart after stop";
      wr(0, 32'h3); idle(200);

      checking = 0;
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule